// File: doc/BRIEF.md
# Issue-Stage Micro-Operation Sequencer

This block sits in the issue stage of a single-issue pipeline whose register file has two read ports and one write port. It accepts one decoded instruction descriptor at a time over a valid/ready handshake and expands it into a run of micro-operations. It issues at most one micro-operation per cycle. Each micro-operation carries a port-select tag that says which register ports it uses, one or two register indices, and a flag that marks the final step of the instruction.

How long an instruction holds the issue slot depends on its class and on a configuration bit that picks a slow iterative multiplier. A down-counter is loaded from a class/configuration length table when the descriptor is accepted. The next descriptor is accepted only in the cycle the final micro-operation leaves, or when the stage is empty. A downstream stall freezes the sequence in place, so no step is dropped and none is repeated.

Top module: `uop_sequencer`

## Requirements
- R1: After synchronous reset, out_valid is 0 and in_ready is 1.
- R2: Class codes 0 (ALU), 1 (branch), 2 (misc), 3 (unknown), 4 (single load), 5 (store with immediate offset) and the reserved code 15 issue exactly one micro-operation. Its tag is 0 (reads A/B), with out_reg_a=ra, out_reg_b=rb and out_last=1, whatever the slow-multiplier bit holds.
- R3: Class 9 (load multiple) and class 10 (store multiple) with word count N issue N micro-operations, for N from 1 to 8 or N=12. Each has tag 4 (word transfer), with out_reg_a=rt+k (mod 32) for step k and out_reg_b=0. A count of 0 is issued as 1.
- R4: For classes 9 and 10, a set base-update bit appends exactly one more micro-operation, with tag 5 (base write) and out_reg_a=ra. On every other class the base-update bit has no effect.
- R5: Class 7 (double load) and class 8 (double store) issue two micro-operations with tag 4, on rt and then rt+1.
- R6: Class 11 (multiply) issues one micro-operation with tag 0 when the slow bit is clear. When the slow bit is set it issues 17 micro-operations: tag 0 first, then 16 with tag 6 (hold, indices 0).
- R7: Class 12 (multiply-accumulate) issues 2 micro-operations when fast and 18 when slow. The first has tag 0 (ra, rb) and the last has tag 1 (reads rt), with any middle steps using tag 6.
- R8: Class 13 (divide) issues 37 micro-operations: tag 0 first, then 36 with tag 6.
- R9: Class 14 (double move) issues tag 2 (write even) with out_reg_a={rt[4:1],0} and out_reg_b={ra[4:1],0}. It then issues tag 3 (write odd) with both indices' bit 0 set to 1.
- R10: Class 6 (store with register offset) issues tag 0 (ra, rb) and then tag 1 with out_reg_a=rt. Only the second step reads the store data.
- R11: A descriptor accepted at a clock edge presents its first micro-operation from that edge. in_ready is 1 only when out_valid is 0, or when out_last and out_ready are both 1, so successive accepts are spaced by exactly the instruction's micro-operation count.
- R12: While out_valid is 1 and out_ready is 0, all outputs hold. Every micro-operation is delivered exactly once, in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Descriptor valid |
| in_ready | output | 1 | Descriptor accepted when high with in_valid |
| in_cls | input | 4 | Instruction class code |
| in_nwords | input | WCNT_W | Word count for multiple transfers |
| in_base_upd | input | 1 | Base register update requested |
| in_slow_mul | input | 1 | Slow iterative multiplier configured |
| in_ra | input | REG_W | First source / base register |
| in_rb | input | REG_W | Second source register |
| in_rt | input | REG_W | Destination / data / first word register |
| out_valid | output | 1 | Micro-operation valid |
| out_ready | input | 1 | Downstream accepts the micro-operation |
| out_port | output | 3 | Port-select tag |
| out_reg_a | output | REG_W | First register index of the step |
| out_reg_b | output | REG_W | Second register index of the step |
| out_last | output | 1 | Final micro-operation of the instruction |

## Verification
Directed pairs of back-to-back descriptors measure the spacing between accepts. This spacing separates the fast and slow multiplier lengths, the divide length, the 12-word transfer with and without a base update, and the zero-count case. A fully open out_ready keeps the measurement free of stalls. Random descriptors of every class are then mixed with random downstream stalls and idle input cycles. Each delivered step is compared against an expected queue, which shows whether steps are lost or repeated under backpressure. A separate hold check catches outputs that move while stalled.

// File: rtl/useq_pkg.sv
package useq_pkg;
  // instruction class codes
  localparam logic [3:0] CLS_ALU         = 4'd0;
  localparam logic [3:0] CLS_BRANCH      = 4'd1;
  localparam logic [3:0] CLS_MISC        = 4'd2;
  localparam logic [3:0] CLS_UNKNOWN     = 4'd3;
  localparam logic [3:0] CLS_LOAD        = 4'd4;
  localparam logic [3:0] CLS_STORE       = 4'd5;
  localparam logic [3:0] CLS_STORE_RR    = 4'd6;
  localparam logic [3:0] CLS_LOAD_DW     = 4'd7;
  localparam logic [3:0] CLS_STORE_DW    = 4'd8;
  localparam logic [3:0] CLS_LOAD_MULTI  = 4'd9;
  localparam logic [3:0] CLS_STORE_MULTI = 4'd10;
  localparam logic [3:0] CLS_MUL         = 4'd11;
  localparam logic [3:0] CLS_MAC         = 4'd12;
  localparam logic [3:0] CLS_DIV         = 4'd13;
  localparam logic [3:0] CLS_MOVE_DW     = 4'd14;

  // port-select tags
  localparam logic [2:0] PS_AB   = 3'd0;
  localparam logic [2:0] PS_T    = 3'd1;
  localparam logic [2:0] PS_WE   = 3'd2;
  localparam logic [2:0] PS_WO   = 3'd3;
  localparam logic [2:0] PS_WORD = 3'd4;
  localparam logic [2:0] PS_BASE = 3'd5;
  localparam logic [2:0] PS_HOLD = 3'd6;

  function automatic int max3(input int a, input int b, input int c);
    int m;
    m = (a > b) ? a : b;
    return (m > c) ? m : c;
  endfunction
endpackage

// File: rtl/useq_len_table.sv
module useq_len_table
  import useq_pkg::*;
#(
  parameter int WCNT_W       = 4,
  parameter int SLOW_MUL_CYC = 17,
  parameter int DIV_CYC      = 37,
  parameter int LEN_W        = 6
) (
  input  logic [3:0]        cls,
  input  logic [WCNT_W-1:0] nwords,
  input  logic              base_upd,
  input  logic              slow_mul,
  output logic [LEN_W-1:0]  len
);
  logic [LEN_W-1:0] words_eff;

  always_comb begin
    words_eff = (nwords == '0) ? LEN_W'(1) : LEN_W'(nwords);
    case (cls)
      CLS_STORE_RR,
      CLS_LOAD_DW,
      CLS_STORE_DW,
      CLS_MOVE_DW:     len = LEN_W'(2);
      CLS_LOAD_MULTI,
      CLS_STORE_MULTI: len = words_eff + LEN_W'(base_upd);
      CLS_MUL:         len = slow_mul ? LEN_W'(SLOW_MUL_CYC) : LEN_W'(1);
      CLS_MAC:         len = slow_mul ? LEN_W'(SLOW_MUL_CYC + 1) : LEN_W'(2);
      CLS_DIV:         len = LEN_W'(DIV_CYC);
      default:         len = LEN_W'(1);
    endcase
  end
endmodule

// File: rtl/useq_shaper.sv
module useq_shaper
  import useq_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int WCNT_W = 4,
  parameter int LEN_W  = 6
) (
  input  logic [3:0]        cls,
  input  logic [WCNT_W-1:0] nwords,
  input  logic [REG_W-1:0]  ra,
  input  logic [REG_W-1:0]  rb,
  input  logic [REG_W-1:0]  rt,
  input  logic [LEN_W-1:0]  step,
  input  logic [LEN_W-1:0]  len,
  output logic [2:0]        port,
  output logic [REG_W-1:0]  reg_a,
  output logic [REG_W-1:0]  reg_b
);
  logic [LEN_W-1:0] words_eff;
  logic [REG_W-1:0] word_reg;
  logic             first;

  always_comb begin
    words_eff = (nwords == '0) ? LEN_W'(1) : LEN_W'(nwords);
    word_reg  = rt + REG_W'(step);
    first     = (step == '0);
    port      = PS_AB;
    reg_a     = ra;
    reg_b     = rb;
    case (cls)
      CLS_STORE_RR: begin
        if (!first) begin
          port  = PS_T;
          reg_a = rt;
          reg_b = '0;
        end
      end
      CLS_LOAD_DW, CLS_STORE_DW: begin
        port  = PS_WORD;
        reg_a = word_reg;
        reg_b = '0;
      end
      CLS_LOAD_MULTI, CLS_STORE_MULTI: begin
        reg_b = '0;
        if (step < words_eff) begin
          port  = PS_WORD;
          reg_a = word_reg;
        end else begin
          port  = PS_BASE;
          reg_a = ra;
        end
      end
      CLS_MUL, CLS_DIV: begin
        if (!first) begin
          port  = PS_HOLD;
          reg_a = '0;
          reg_b = '0;
        end
      end
      CLS_MAC: begin
        if (!first && step == len - LEN_W'(1)) begin
          port  = PS_T;
          reg_a = rt;
          reg_b = '0;
        end else if (!first) begin
          port  = PS_HOLD;
          reg_a = '0;
          reg_b = '0;
        end
      end
      CLS_MOVE_DW: begin
        port  = first ? PS_WE : PS_WO;
        reg_a = {rt[REG_W-1:1], ~first};
        reg_b = {ra[REG_W-1:1], ~first};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/useq_counter.sv
module useq_counter #(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic             advance,
  output logic [LEN_W-1:0] step,
  output logic [LEN_W-1:0] remain
);
  always_ff @(posedge clk) begin
    if (rst) begin
      step   <= '0;
      remain <= '0;
    end else if (load) begin
      step   <= '0;
      remain <= len_in - LEN_W'(1);
    end else if (advance) begin
      step   <= step + LEN_W'(1);
      remain <= remain - LEN_W'(1);
    end
  end

  // R12
  adv_not_empty_chk: assert property (@(posedge clk) disable iff (rst)
    advance |-> remain != '0);

  // R3
  load_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
    load |-> len_in != '0);
endmodule

// File: rtl/uop_sequencer.sv
module uop_sequencer
  import useq_pkg::*;
#(
  parameter int REG_W        = 5,
  parameter int WCNT_W       = 4,
  parameter int SLOW_MUL_CYC = 17,
  parameter int DIV_CYC      = 37
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [3:0]        in_cls,
  input  logic [WCNT_W-1:0] in_nwords,
  input  logic              in_base_upd,
  input  logic              in_slow_mul,
  input  logic [REG_W-1:0]  in_ra,
  input  logic [REG_W-1:0]  in_rb,
  input  logic [REG_W-1:0]  in_rt,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [2:0]        out_port,
  output logic [REG_W-1:0]  out_reg_a,
  output logic [REG_W-1:0]  out_reg_b,
  output logic              out_last
);
  localparam int LONGEST = max3(DIV_CYC, SLOW_MUL_CYC + 1, (1 << WCNT_W));
  localparam int LEN_W   = $clog2(LONGEST + 1);

  logic              accept, advance, drain;
  logic [LEN_W-1:0]  len_new, len_q, step_q, remain_q, step_sel, len_sel;
  logic [3:0]        cls_q, cls_sel;
  logic [WCNT_W-1:0] nw_q, nw_sel;
  logic [REG_W-1:0]  ra_q, rb_q, rt_q, ra_sel, rb_sel, rt_sel;
  logic [2:0]        port_n;
  logic [REG_W-1:0]  rega_n, regb_n;
  logic              last_n;

  assign in_ready = !out_valid || (out_ready && out_last);
  assign accept   = in_valid && in_ready;
  assign advance  = out_valid && out_ready && !out_last;
  assign drain    = out_valid && out_ready && out_last && !accept;

  useq_len_table #(
    .WCNT_W(WCNT_W), .SLOW_MUL_CYC(SLOW_MUL_CYC), .DIV_CYC(DIV_CYC), .LEN_W(LEN_W)
  ) u_len (
    .cls(in_cls), .nwords(in_nwords), .base_upd(in_base_upd),
    .slow_mul(in_slow_mul), .len(len_new)
  );

  useq_counter #(.LEN_W(LEN_W)) u_cnt (
    .clk(clk), .rst(rst), .load(accept), .len_in(len_new),
    .advance(advance), .step(step_q), .remain(remain_q)
  );

  // the step shown next comes either from a fresh descriptor or the held one
  always_comb begin
    cls_sel  = accept ? in_cls    : cls_q;
    nw_sel   = accept ? in_nwords : nw_q;
    ra_sel   = accept ? in_ra     : ra_q;
    rb_sel   = accept ? in_rb     : rb_q;
    rt_sel   = accept ? in_rt     : rt_q;
    len_sel  = accept ? len_new   : len_q;
    step_sel = accept ? '0        : step_q + LEN_W'(1);
    last_n   = accept ? (len_new == LEN_W'(1)) : (remain_q == LEN_W'(1));
  end

  useq_shaper #(.REG_W(REG_W), .WCNT_W(WCNT_W), .LEN_W(LEN_W)) u_shape (
    .cls(cls_sel), .nwords(nw_sel), .ra(ra_sel), .rb(rb_sel), .rt(rt_sel),
    .step(step_sel), .len(len_sel),
    .port(port_n), .reg_a(rega_n), .reg_b(regb_n)
  );

  // held descriptor: data registers without reset
  always_ff @(posedge clk) begin
    if (accept) begin
      cls_q <= in_cls;
      nw_q  <= in_nwords;
      ra_q  <= in_ra;
      rb_q  <= in_rb;
      rt_q  <= in_rt;
      len_q <= len_new;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
    end else if (accept || advance) begin
      out_valid <= 1'b1;
    end else if (drain) begin
      out_valid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_port  <= PS_AB;
      out_reg_a <= '0;
      out_reg_b <= '0;
      out_last  <= 1'b0;
    end else if (accept || advance) begin
      out_port  <= port_n;
      out_reg_a <= rega_n;
      out_reg_b <= regb_n;
      out_last  <= last_n;
    end
  end

  // R12
  stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=>
      out_valid && $stable({out_port, out_reg_a, out_reg_b, out_last}));

  // R11
  accept_issue_chk: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  // R11
  drain_idle_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && out_ready && out_last && !in_valid |=> !out_valid);

  // R7
  mac_acc_last_chk: assert property (@(posedge clk) disable iff (rst)
    out_valid && cls_q == CLS_MAC && out_port == PS_T |-> out_last);
endmodule

// File: tb/uop_sequencer_tb.sv
module uop_sequencer_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_ready;
  logic [3:0] in_cls = '0;
  logic [3:0] in_nwords = '0;
  logic       in_base_upd = 1'b0;
  logic       in_slow_mul = 1'b0;
  logic [4:0] in_ra = '0, in_rb = '0, in_rt = '0;
  logic       out_valid;
  logic       out_ready = 1'b1;
  logic [2:0] out_port;
  logic [4:0] out_reg_a, out_reg_b;
  logic       out_last;

  int checks = 0;
  int fails  = 0;
  int cyc = 0, last_acc = 0, acc_gap = 0;
  int wd = 0;
  bit rmode = 1'b1;
  string tag_ovr = "";
  logic [13:0] eq[$];
  string       tq[$];
  bit          prev_stall = 1'b0;
  logic [13:0] prev_act;

  always #10 clk = ~clk;  // 50 MHz

  uop_sequencer u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_cls(in_cls), .in_nwords(in_nwords), .in_base_upd(in_base_upd),
    .in_slow_mul(in_slow_mul), .in_ra(in_ra), .in_rb(in_rb), .in_rt(in_rt),
    .out_valid(out_valid), .out_ready(out_ready), .out_port(out_port),
    .out_reg_a(out_reg_a), .out_reg_b(out_reg_b), .out_last(out_last)
  );

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int exp_len(input logic [3:0] c, input logic [3:0] nw,
                                 input logic bu, input logic sl);
    int w;
    w = (nw == 0) ? 1 : int'(nw);
    case (c)
      6, 7, 8, 14: return 2;
      9, 10:       return w + (bu ? 1 : 0);
      11:          return sl ? 17 : 1;
      12:          return sl ? 18 : 2;
      13:          return 37;
      default:     return 1;
    endcase
  endfunction

  function automatic logic [13:0] exp_uop(input logic [3:0] c, input logic [3:0] nw,
      input logic [4:0] ra, input logic [4:0] rb, input logic [4:0] rt,
      input int k, input int n);
    logic [2:0] p;
    logic [4:0] a, b, wr;
    int w;
    w  = (nw == 0) ? 1 : int'(nw);
    wr = rt + 5'(k);
    p = 3'd0; a = ra; b = rb;
    case (c)
      6:       if (k != 0) begin p = 3'd1; a = rt; b = 0; end
      7, 8:    begin p = 3'd4; a = wr; b = 0; end
      9, 10:   if (k < w) begin p = 3'd4; a = wr; b = 0; end
               else begin p = 3'd5; a = ra; b = 0; end
      11, 13:  if (k != 0) begin p = 3'd6; a = 0; b = 0; end
      12:      if (k != 0 && k == n - 1) begin p = 3'd1; a = rt; b = 0; end
               else if (k != 0) begin p = 3'd6; a = 0; b = 0; end
      14:      if (k == 0) begin p = 3'd2; a = {rt[4:1], 1'b0}; b = {ra[4:1], 1'b0}; end
               else begin p = 3'd3; a = {rt[4:1], 1'b1}; b = {ra[4:1], 1'b1}; end
      default: ;
    endcase
    return {p, a, b, (k == n - 1)};
  endfunction

  function automatic string cls_tag(input logic [3:0] c, input int k, input logic [3:0] nw);
    int w;
    w = (nw == 0) ? 1 : int'(nw);
    case (c)
      6:       return "R10";
      7, 8:    return "R5";
      9, 10:   return (k < w) ? "R3" : "R4";
      11:      return "R6";
      12:      return "R7";
      13:      return "R8";
      14:      return "R9";
      default: return "R2";
    endcase
  endfunction

  task automatic push_seq();
    int n;
    n = exp_len(in_cls, in_nwords, in_base_upd, in_slow_mul);
    for (int k = 0; k < n; k++) begin
      eq.push_back(exp_uop(in_cls, in_nwords, in_ra, in_rb, in_rt, k, n));
      tq.push_back(tag_ovr != "" ? tag_ovr : cls_tag(in_cls, k, in_nwords));
    end
  endtask

  // monitor: samples away from the active edge
  always @(negedge clk) begin
    logic [13:0] act, exp;
    string t;
    cyc++;
    act = {out_port, out_reg_a, out_reg_b, out_last};
    if (rst) begin
      prev_stall = 1'b0;
    end else begin
      if (prev_stall) begin
        check(out_valid == 1'b1, "R12", "valid dropped during stall", 32'(out_valid), 32'd1);
        check(act == prev_act, "R12", "outputs moved during stall", 32'(act), 32'(prev_act));
      end
      if (out_valid && out_ready) begin
        if (eq.size() == 0) begin
          check(1'b0, "R12", "unexpected micro-op", 32'(act), 32'd0);
        end else begin
          exp = eq.pop_front();
          t   = tq.pop_front();
          check(act == exp, t, "micro-op {port,a,b,last}", 32'(act), 32'(exp));
        end
      end
      if (in_valid && in_ready) begin
        push_seq();
        acc_gap  = cyc - last_acc;
        last_acc = cyc;
      end
      prev_stall = out_valid && !out_ready;
      prev_act   = act;
    end
  end

  always @(posedge clk) begin
    #1;
    out_ready = rmode ? 1'b1 : (($urandom % 4) != 0);
  end

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      check(1'b0, "R11", "watchdog expired", 32'(wd), 32'd150000);
      finish_run();
    end
  end

  task automatic send(input logic [3:0] c, input logic [3:0] nw, input logic bu,
                      input logic sl, input logic [4:0] ra, input logic [4:0] rb,
                      input logic [4:0] rt);
    bit got;
    in_valid = 1'b1; in_cls = c; in_nwords = nw; in_base_upd = bu;
    in_slow_mul = sl; in_ra = ra; in_rb = rb; in_rt = rt;
    got = 1'b0;
    while (!got) begin
      @(negedge clk);
      got = in_valid && in_ready;
      @(posedge clk);
      #1;
    end
    in_valid = 1'b0;
  endtask

  task automatic gap_pair(input logic [3:0] c, input logic [3:0] nw, input logic bu,
                          input logic sl, input int expgap, input string tag);
    send(c, nw, bu, sl, 5'd3, 5'd9, 5'd30);
    send(4'd0, 4'd0, 1'b0, 1'b0, 5'd1, 5'd2, 5'd4);
    check(acc_gap == expgap, tag, "accept spacing", 32'(acc_gap), 32'(expgap));
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'd20240611);
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "out_valid after reset", 32'(out_valid), 32'd0);
    check(in_ready == 1'b1, "R1", "in_ready after reset", 32'(in_ready), 32'd1);
    @(posedge clk); #1;

    // directed spacing checks with downstream always ready
    gap_pair(4'd13, 4'd0, 1'b0, 1'b0, 37, "R8");
    gap_pair(4'd0,  4'd0, 1'b0, 1'b0, 1,  "R11");
    gap_pair(4'd11, 4'd0, 1'b0, 1'b1, 17, "R6");
    gap_pair(4'd11, 4'd0, 1'b0, 1'b0, 1,  "R6");
    gap_pair(4'd12, 4'd0, 1'b0, 1'b1, 18, "R7");
    gap_pair(4'd12, 4'd0, 1'b0, 1'b0, 2,  "R7");
    gap_pair(4'd9,  4'd12, 1'b1, 1'b0, 13, "R4");
    gap_pair(4'd10, 4'd12, 1'b0, 1'b0, 12, "R3");
    gap_pair(4'd10, 4'd0, 1'b0, 1'b0, 1,  "R3");
    gap_pair(4'd6,  4'd0, 1'b0, 1'b0, 2,  "R10");
    gap_pair(4'd14, 4'd0, 1'b0, 1'b0, 2,  "R9");
    gap_pair(4'd7,  4'd0, 1'b0, 1'b0, 2,  "R5");
    gap_pair(4'd15, 4'd0, 1'b1, 1'b1, 1,  "R2");
    tag_ovr = "R4";
    gap_pair(4'd13, 4'd5, 1'b1, 1'b0, 37, "R4");
    gap_pair(4'd8,  4'd3, 1'b1, 1'b0, 2,  "R4");
    tag_ovr = "";

    // random traffic with backpressure
    rmode = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [3:0] c, nw;
      int v;
      c = 4'($urandom % 16);
      v = $urandom % 10;
      nw = (v == 9) ? 4'd12 : 4'(v);
      send(c, nw, 1'($urandom % 2), 1'($urandom % 2),
           5'($urandom), 5'($urandom), 5'($urandom));
      if (($urandom % 4) == 0) begin
        @(posedge clk); #1;
      end
    end

    rmode = 1'b1;
    while (eq.size() != 0 || out_valid) begin
      @(posedge clk); #1;
    end
    @(negedge clk);
    check(eq.size() == 0, "R12", "undelivered micro-ops", 32'(eq.size()), 32'd0);
    finish_run();
  end
endmodule